// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block turns the peripheral bus clock into the two timing strobes a serial port needs. It divides the bus clock by a programmable divisor, an integer of up to 13 bits plus a fraction in eighths. Each time the division completes it raises a one-cycle oversampling strobe for the receiver, at sixteen times the bit rate. A second one-cycle strobe for the transmitter is derived from every sixteenth oversampling strobe. Both strobes are registered and synchronous to the bus clock.

The fraction is realised by dithering. A small accumulator adds the fractional part once per period, and each carry stretches one of the following periods by a single bus clock. Over any eight periods the average divisor is exact. The phase error of any single strobe stays below one bus clock.

The divisor inputs are copied into a shadow register. The copy is made only while the generator is idle, or at the end of a count period. A period that has started therefore always finishes with the divisor it began with. An integer divisor of zero parks the generator.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it, `rx_tick` and `tx_tick` are low.
- R2: With fraction 0 and integer divisor N ≥ 1, `rx_tick` pulses exactly every N bus cycles.
- R3: With fraction F (eighths, `div_frac` bits 2:0) and integer N, every `rx_tick` period is N or N+1 cycles. Any 8 consecutive periods total 8N+F cycles, so a window of 8·(8N+F) cycles holds 64 ± 1 ticks.
- R4: `tx_tick` pulses only together with `rx_tick`, on every 16th `rx_tick` counted since the generator last started.
- R5: A divisor change while running takes effect only after the current period ends. The period in progress keeps the old length.
- R6: With an integer divisor of 0, both outputs stay low. When a nonzero N is then applied with `en` high, the first `rx_tick` appears on the (N+1)th cycle.
- R7: While `en` is low, both outputs are low and the divide-by-16 stage is cleared. After re-enabling, the first `tx_tick` comes with the 16th `rx_tick`.
- R8: When `en` rises with a nonzero divisor already applied, the first `rx_tick` is visible N cycles after `en` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Generator run enable |
| div_int | input | 13 | Integer part of the divisor, in bus clocks |
| div_frac | input | 3 | Fractional part of the divisor, in eighths |
| rx_tick | output | 1 | Oversampling strobe, one cycle wide, 16 per bit |
| tx_tick | output | 1 | Bit strobe, one cycle wide |

## Verification
Two events can fall in the same bus cycle. The first is a period end, which raises `rx_tick`, advances the dither accumulator and reloads the shadow divisor. The second is the sixteenth count of the divide-by-16 stage, which raises `tx_tick` in that same cycle.

The bench provokes the first pair by changing `div_int` on the cycle an `rx_tick` is seen. It then measures that the next period still has the old length and the one after has the new length. For the second pair, every `tx_tick` in every run is compared against a running count of `rx_tick` pulses. A `tx_tick` that is not coincident with a multiple-of-16 count is reported as a mismatch, including after a disable and re-enable.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;
  localparam int DEF_INT_W  = 13;
  localparam int DEF_FRAC_W = 3;
  localparam int DEF_OVS    = 16;

  // Counter width: one spare bit so that N plus a stretch cycle never wraps.
  function automatic int period_cnt_w(input int int_w);
    return int_w + 1;
  endfunction
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int INT_W  = baud_gen_pkg::DEF_INT_W,
  parameter int FRAC_W = baud_gen_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  input  logic              period_end,
  output logic [INT_W-1:0]  sh_int,
  output logic [FRAC_W-1:0] sh_frac,
  output logic              run
);
  logic load;

  // Running needs an enable and a nonzero integer divisor in the shadow copy.
  assign run  = en && (sh_int != '0);
  // Copy inputs while idle, or on the cycle a period completes.
  assign load = !run || period_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_int  <= '0;
      sh_frac <= '0;
    end else if (load) begin
      sh_int  <= div_int;
      sh_frac <= div_frac;
    end
  end

  // R5: mid-period the divisor in use never moves
  p_hold_mid_period_r5: assert property (@(posedge clk) disable iff (rst)
    (run && !period_end) |=> ($stable(sh_int) && $stable(sh_frac)));
endmodule

// File: rtl/baud_frac_counter.sv
module baud_frac_counter #(
  parameter int INT_W  = baud_gen_pkg::DEF_INT_W,
  parameter int FRAC_W = baud_gen_pkg::DEF_FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [INT_W-1:0]  sh_int,
  input  logic [FRAC_W-1:0] sh_frac,
  output logic              period_end,
  output logic              rx_tick
);
  localparam int CW = baud_gen_pkg::period_cnt_w(INT_W);

  logic [CW-1:0]     cnt;
  logic [CW-1:0]     limit;
  logic [FRAC_W-1:0] acc;
  logic [FRAC_W:0]   acc_sum;
  logic              stretch;

  assign limit      = {1'b0, sh_int} + {{(CW-1){1'b0}}, stretch};
  assign period_end = run && ((cnt + CW'(1)) == limit);
  assign acc_sum    = {1'b0, acc} + {1'b0, sh_frac};

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt     <= '0;
      acc     <= '0;
      stretch <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      rx_tick <= period_end;
      if (period_end) begin
        cnt     <= '0;
        acc     <= acc_sum[FRAC_W-1:0];
        stretch <= acc_sum[FRAC_W];
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R2: the period count never runs past its limit
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < limit));
  // R3: a zero fraction never produces a stretched period
  p_no_stretch_r3: assert property (@(posedge clk) disable iff (rst)
    (run && period_end && sh_frac == '0 && acc == '0) |=> !stretch);
endmodule

// File: rtl/baud_ovs_div.sv
module baud_ovs_div #(
  parameter int OVS = baud_gen_pkg::DEF_OVS
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic rx_pulse,
  output logic tx_tick
);
  localparam int DW = (OVS > 1) ? $clog2(OVS) : 1;

  generate
    if (OVS <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst || !run) tx_tick <= 1'b0;
        else             tx_tick <= rx_pulse;
      end
    end else begin : g_count
      logic [DW-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          div_cnt <= '0;
          tx_tick <= 1'b0;
        end else begin
          tx_tick <= 1'b0;
          if (rx_pulse) begin
            if (div_cnt == DW'(OVS - 1)) begin
              div_cnt <= '0;
              tx_tick <= 1'b1;
            end else begin
              div_cnt <= div_cnt + DW'(1);
            end
          end
        end
      end

      // R7: an idle generator leaves the divide stage cleared
      p_div_clear_r7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (div_cnt == '0));
    end
  endgenerate
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int INT_W  = baud_gen_pkg::DEF_INT_W,
  parameter int FRAC_W = baud_gen_pkg::DEF_FRAC_W,
  parameter int OVS    = baud_gen_pkg::DEF_OVS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              rx_tick,
  output logic              tx_tick
);
  logic [INT_W-1:0]  sh_int;
  logic [FRAC_W-1:0] sh_frac;
  logic              run;
  logic              period_end;

  baud_div_latch #(.INT_W(INT_W), .FRAC_W(FRAC_W)) latch_i (
    .clk(clk), .rst(rst), .en(en), .div_int(div_int), .div_frac(div_frac),
    .period_end(period_end), .sh_int(sh_int), .sh_frac(sh_frac), .run(run)
  );

  baud_frac_counter #(.INT_W(INT_W), .FRAC_W(FRAC_W)) cnt_i (
    .clk(clk), .rst(rst), .run(run), .sh_int(sh_int), .sh_frac(sh_frac),
    .period_end(period_end), .rx_tick(rx_tick)
  );

  baud_ovs_div #(.OVS(OVS)) ovs_i (
    .clk(clk), .rst(rst), .run(run), .rx_pulse(period_end), .tx_tick(tx_tick)
  );

  // R6 / R7: an idle generator drives no strobes
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!rx_tick && !tx_tick));
  // R4: a bit strobe is always coincident with an oversampling strobe
  p_tx_with_rx_r4: assert property (@(posedge clk) disable iff (rst)
    tx_tick |-> rx_tick);
  // R1: outputs are low the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!rx_tick && !tx_tick));
endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [12:0] div_int  = '0;
  logic [2:0]  div_frac = '0;
  logic        rx_tick, tx_tick;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_total = 0;

  always #10 clk = ~clk;

  baud_tick_gen dut_i (
    .clk(clk), .rst(rst), .en(en), .div_int(div_int), .div_frac(div_frac),
    .rx_tick(rx_tick), .tx_tick(tx_tick)
  );

  localparam int NV = 8;
  localparam int VEC_N [NV] = '{32, 65, 97, 195, 390, 1, 3, 7};
  localparam int VEC_F [NV] = '{ 4,  1,  5,   2,   5, 0, 3, 0};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  task automatic wait_rx(input int lim, output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rx_tick && cyc < lim);
  endtask

  task automatic restart(input int n, input int f);
    @(negedge clk);
    en = 1'b0;
    repeat (3) @(negedge clk);
    div_int  = 13'(n);
    div_frac = 3'(f);
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    int cyc, rxc, txc, gap, gmin, gmax, bad_al, k;

    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      chk(!rx_tick && !tx_tick, "R1 reset", {30'd0, rx_tick, tx_tick}, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(!rx_tick && !tx_tick, "R1 post-reset", {30'd0, rx_tick, tx_tick}, 0);

    // Vector table: R2 / R3 / R4 per divisor
    for (int v = 0; v < NV; v++) begin
      int n = VEC_N[v];
      int f = VEC_F[v];
      int w = 8 * (8 * n + f);
      restart(n, f);
      rxc = 0; txc = 0; gap = 0; gmin = 1 << 20; gmax = 0; bad_al = 0;
      for (int c = 0; c < w; c++) begin
        @(negedge clk);
        gap++;
        if (rx_tick) begin
          rxc++;
          if (gap < gmin) gmin = gap;
          if (gap > gmax) gmax = gap;
          gap = 0;
        end
        if (tx_tick) begin
          txc++;
          if (!(rx_tick && (rxc % 16 == 0))) bad_al++;
        end
      end
      chk(rxc >= 63 && rxc <= 65, "R3 rx count", rxc, 64);
      chk(txc >= 3 && txc <= 5, "R4 tx count", txc, 4);
      chk(bad_al == 0, "R4 tx alignment", bad_al, 0);
      chk(gmin >= n, "R3 min period", gmin, n);
      if (f == 0) chk(gmax == n, "R2 exact period", gmax, n);
      else        chk(gmax <= n + 1, "R3 max period", gmax, n + 1);
    end

    // R8: first tick N cycles after enable
    restart(20, 0);
    wait_rx(100, cyc);
    chk(cyc == 20, "R8 first tick", cyc, 20);

    // R5: change mid-run takes effect after the running period
    restart(100, 0);
    wait_rx(300, cyc);
    div_int = 13'd10;
    wait_rx(300, cyc);
    chk(cyc == 100, "R5 old period kept", cyc, 100);
    wait_rx(300, cyc);
    chk(cyc == 10, "R5 new period", cyc, 10);

    // R6: zero integer divisor parks the generator
    restart(0, 3);
    rxc = 0;
    repeat (200) begin
      @(negedge clk);
      if (rx_tick || tx_tick) rxc++;
    end
    chk(rxc == 0, "R6 zero divisor quiet", rxc, 0);
    div_int = 13'd5;
    div_frac = 3'd0;
    wait_rx(50, cyc);
    chk(cyc == 6, "R6 restart from zero", cyc, 6);

    // R7: disable clears divide stage
    restart(4, 0);
    for (int i = 0; i < 5; i++) wait_rx(50, cyc);
    @(negedge clk);
    en = 1'b0;
    rxc = 0;
    repeat (20) begin
      @(negedge clk);
      if (rx_tick || tx_tick) rxc++;
    end
    chk(rxc == 0, "R7 disabled quiet", rxc, 0);
    en = 1'b1;
    k = 0;
    do begin
      wait_rx(50, cyc);
      k++;
    end while (!tx_tick && k < 40);
    chk(k == 16, "R7 tx after re-enable", k, 16);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule